// File: doc/BRIEF.md
# Oscillator Delay-Sensor Grid with Residue Ring Counters

This block monitors on-die activity through a grid of delay-sensor cells, four rows by five columns. Every cell receives the output of a nearby free-running oscillator whose frequency drifts with local supply and temperature, both of which respond to switching activity around the cell. Each cell counts the rising edges of its oscillator during a measurement window. The window is called a bin and spans a run of consecutive test vectors. A cell whose count departs from its own history across bins marks a window in which the surrounding logic behaved unusually.

Counting uses residue arithmetic rather than a binary counter. Each cell holds four small one-hot rings with pairwise coprime lengths 7, 11, 13 and 15. Every ring advances by one position per edge, so no carry chain is ever built. The four ring positions identify any edge count below 15015. Host software rebuilds the count from the residues with the Chinese Remainder Theorem.

A control sequencer clears all cells, opens the window for a programmable number of clock cycles, freezes the rings and then opens a readout phase. During readout the host selects one cell at a time and collects its four encoded residues over a valid/ready handshake.

Top module: `rosg_grid`

## Requirements
- R1: While reset is held and in the cycle after it, `rd_valid_o` and `bin_ready_o` are 0.
- R2: A `start_i` pulse, accepted only when the grid is idle or in readout, clears every ring to position 0 and opens a counting window of `bin_len_i` clock cycles (at least one). The clear is followed by a freeze cycle, after which `bin_ready_o` rises.
- R3: After a bin, the residue field k of a cell equals the number of rising oscillator edges seen in the window modulo m_k, with m_0=7, m_1=11, m_2=13, m_3=15. Field k sits at bits [4k+3:4k] of `rd_res_o` as a binary index from 0 to m_k-1.
- R4: Oscillator edges that arrive while `bin_ready_o` is 1 leave every residue unchanged.
- R5: A `start_i` pulse that arrives while a window is counting is ignored. The count of that window includes edges both before and after the pulse.
- R6: A request (`rd_req_i`) whose `rd_sel_i` is 20 or higher produces no response.
- R7: While `rd_valid_o` is 1 and `rd_ready_i` is 0, `rd_res_o` and `rd_cell_o` are held stable, and new requests are ignored.
- R8: Reading a cell does not disturb it, so repeated reads of the same cell return the same residues. `rd_cell_o` echoes the selected cell index, where index = row*5 + column.
- R9: `rd_valid_o` is only ever 1 while `bin_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a bin |
| bin_len_i | input | 16 | Counting window length in clock cycles |
| osc_i | input | 20 | Oscillator outputs, one per cell (bit = row*5+column) |
| rd_sel_i | input | 5 | Cell selected for a read |
| rd_req_i | input | 1 | Read request for the selected cell |
| rd_ready_i | input | 1 | Host accepts the presented residues |
| rd_valid_o | output | 1 | Residues of a requested cell are presented |
| rd_res_o | output | 16 | Four 4-bit residue indices, ring 0 in the low nibble |
| rd_cell_o | output | 5 | Index of the cell whose residues are presented |
| bin_ready_o | output | 1 | Bin finished; rings frozen and readable |

## Verification
Two bins give every cell a different edge total. In the first bin the totals run from 3 to 212, so each ring wraps several times and at a different phase; a ring of the wrong length, or a field in the wrong position, therefore shows up in some cell. The second bin uses totals of 0 to 39, with one cell left at zero, and pulses start halfway through the edge train; this separates an ignored restart from one that clears the rings. Edges driven during readout, repeated reads, an out-of-range select and a held-off ready check that the readout path neither disturbs the counts nor loses or duplicates responses.

// File: rtl/rosg_pkg.sv
// Shared constants and types for the oscillator sensor grid.
// Assumes every ring modulus fits in MAX_MOD and that the moduli are pairwise coprime.
package rosg_pkg;

    localparam int unsigned MAX_MOD = 15;
    localparam int unsigned IDX_W   = $clog2(MAX_MOD + 1);

    // Ring length for residue lane k (pairwise coprime set).
    function automatic int unsigned ring_mod(input int unsigned k);
        case (k)
            0:       return 7;
            1:       return 11;
            2:       return 13;
            default: return 15;
        endcase
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_COUNT,
        ST_FREEZE,
        ST_READOUT
    } seq_state_t;

endpackage

// File: rtl/rosg_sync_edge.sv
// Brings one asynchronous oscillator line into the clock domain and flags its rising edges.
// Assumes the oscillator stays high and low for at least two clock cycles each.
module rosg_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic meta_q;
    logic stab_q;
    logic prev_q;

    // Two-flop synchronizer followed by a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign rise_o = stab_q & ~prev_q;

endmodule

// File: rtl/rosg_onehot_ring.sv
// One-hot rotating ring of length MOD; its position is the edge count modulo MOD.
// Assumes MOD fits in IDX_W bits when encoded.
module rosg_onehot_ring #(
    parameter int unsigned MOD   = 7,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [MOD-1:0] ring_q;

    // Rotate the single hot bit upward on each counted edge; clear returns to position 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ring_q <= MOD'(1);
        end else if (step_i) begin
            ring_q <= {ring_q[MOD-2:0], ring_q[MOD-1]};
        end
    end

    // Encode the hot position as a binary index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < MOD; i++) begin
            if (ring_q[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rosg_cell.sv
// One sensor cell: synchronizes its oscillator and advances NUM_RINGS residue rings per edge.
// Assumes count_en_i and clear_i come from the common sequencer.
module rosg_cell
    import rosg_pkg::*;
#(
    parameter int unsigned NUM_RINGS = 4,
    localparam int unsigned RES_W    = NUM_RINGS * IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_i,
    input  logic             clear_i,
    input  logic             count_en_i,
    output logic [RES_W-1:0] res_o
);

    logic rise;
    logic step;

    rosg_sync_edge sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (osc_i),
        .rise_o  (rise)
    );

    assign step = rise & count_en_i;

    for (genvar k = 0; k < NUM_RINGS; k++) begin : g_ring
        rosg_onehot_ring #(
            .MOD   (ring_mod(k)),
            .IDX_W (IDX_W)
        ) ring_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear_i),
            .step_i  (step),
            .idx_o   (res_o[k*IDX_W +: IDX_W])
        );
    end

endmodule

// File: rtl/rosg_ctrl.sv
// Bin sequencer: idle, clear, count for a programmed window, freeze, then readout.
// Assumes start_i is a single-cycle pulse; starts are honoured only in idle or readout.
module rosg_ctrl
    import rosg_pkg::*;
#(
    parameter int unsigned WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIN_W-1:0] bin_len_i,
    output logic             clear_o,
    output logic             count_en_o,
    output logic             readout_o
);

    seq_state_t       state_q;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W:0]   win_next;

    assign win_next = {1'b0, win_q} + (WIN_W+1)'(1);

    // Advance the sequencer and time the counting window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) state_q <= ST_CLEAR;
                end
                ST_CLEAR: begin
                    state_q <= ST_COUNT;
                    win_q   <= '0;
                end
                ST_COUNT: begin
                    if (win_next >= {1'b0, bin_len_i}) state_q <= ST_FREEZE;
                    else                               win_q   <= win_next[WIN_W-1:0];
                end
                ST_FREEZE: begin
                    state_q <= ST_READOUT;
                end
                ST_READOUT: begin
                    if (start_i) state_q <= ST_CLEAR;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign clear_o    = (state_q == ST_CLEAR);
    assign count_en_o = (state_q == ST_COUNT);
    assign readout_o  = (state_q == ST_READOUT);

endmodule

// File: rtl/rosg_grid.sv
// Grid of NUM_ROWS x NUM_COLS oscillator sensor cells sharing one bin sequencer, with a
// selected-cell readout register on a valid/ready handshake.
// Assumes the host rebuilds counts from residues; cell index = row*NUM_COLS + column.
module rosg_grid
    import rosg_pkg::*;
#(
    parameter int unsigned NUM_ROWS  = 4,
    parameter int unsigned NUM_COLS  = 5,
    parameter int unsigned NUM_RINGS = 4,
    parameter int unsigned WIN_W     = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     start_i,
    input  logic [WIN_W-1:0]                         bin_len_i,
    input  logic [NUM_ROWS*NUM_COLS-1:0]             osc_i,
    input  logic [$clog2(NUM_ROWS*NUM_COLS)-1:0]     rd_sel_i,
    input  logic                                     rd_req_i,
    input  logic                                     rd_ready_i,
    output logic                                     rd_valid_o,
    output logic [NUM_RINGS*IDX_W-1:0]               rd_res_o,
    output logic [$clog2(NUM_ROWS*NUM_COLS)-1:0]     rd_cell_o,
    output logic                                     bin_ready_o
);

    localparam int unsigned CELLS = NUM_ROWS * NUM_COLS;
    localparam int unsigned SEL_W = $clog2(CELLS);
    localparam int unsigned RES_W = NUM_RINGS * IDX_W;

    logic                   clear;
    logic                   count_en;
    logic                   readout;
    logic [CELLS*RES_W-1:0] res_flat;
    logic [RES_W-1:0]       picked;
    logic                   sel_ok;
    logic                   hold;

    rosg_ctrl #(
        .WIN_W (WIN_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .bin_len_i  (bin_len_i),
        .clear_o    (clear),
        .count_en_o (count_en),
        .readout_o  (readout)
    );

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            rosg_cell #(
                .NUM_RINGS (NUM_RINGS)
            ) cell_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .osc_i      (osc_i[r*NUM_COLS + c]),
                .clear_i    (clear),
                .count_en_i (count_en),
                .res_o      (res_flat[(r*NUM_COLS + c)*RES_W +: RES_W])
            );
        end
    end

    // Select the residues of the requested cell.
    always_comb begin
        picked = '0;
        for (int i = 0; i < CELLS; i++) begin
            if (rd_sel_i == SEL_W'(i)) picked = res_flat[i*RES_W +: RES_W];
        end
    end

    assign sel_ok = ({1'b0, rd_sel_i} < (SEL_W+1)'(CELLS));
    assign hold   = rd_valid_o & ~rd_ready_i;

    // Readout register: capture on an in-range request, hold under backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_res_o   <= '0;
            rd_cell_o  <= '0;
        end else if (!readout || start_i) begin
            rd_valid_o <= 1'b0;
        end else if (!hold) begin
            rd_valid_o <= rd_req_i & sel_ok;
            if (rd_req_i && sel_ok) begin
                rd_res_o  <= picked;
                rd_cell_o <= rd_sel_i;
            end
        end
    end

    assign bin_ready_o = readout;

endmodule

// File: rtl/rosg_grid_chk.sv
// Property checker for the sensor grid, attached to the top module by bind.
// Assumes residue lane 0 of cell 0 uses modulus 7 and lane 3 uses 15.
module rosg_grid_chk #(
    parameter int unsigned CELLS = 20,
    parameter int unsigned RES_W = 16,
    parameter int unsigned SEL_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_ready_i,
    input logic                   rd_valid_o,
    input logic [RES_W-1:0]       rd_res_o,
    input logic [SEL_W-1:0]       rd_cell_o,
    input logic                   bin_ready_o,
    input logic [CELLS*RES_W-1:0] res_flat
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid_o && !bin_ready_o));

    // R4
    frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_ready_o && $past(bin_ready_o)) |-> $stable(res_flat));

    // R6
    cell_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ({1'b0, rd_cell_o} < (SEL_W+1)'(CELLS)));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_res_o) && $stable(rd_cell_o)));

    // R9
    valid_in_readout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> bin_ready_o);

    // R3
    residue_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_flat[3:0] < 4'd7) && (res_flat[15:12] < 4'd15));

endmodule

bind rosg_grid rosg_grid_chk #(
    .CELLS (CELLS),
    .RES_W (RES_W),
    .SEL_W (SEL_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_ready_i  (rd_ready_i),
    .rd_valid_o  (rd_valid_o),
    .rd_res_o    (rd_res_o),
    .rd_cell_o   (rd_cell_o),
    .bin_ready_o (bin_ready_o),
    .res_flat    (res_flat)
);

// File: tb/rosg_grid_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for the sensor grid: a driver pushes expected residues, a monitor compares.
module rosg_grid_tb_top;

    localparam int CELLS = 20;
    localparam int TCLK  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] bin_len_i = 16'd1000;
    logic [19:0] osc_i = '0;
    logic [4:0]  rd_sel_i = '0;
    logic        rd_req_i = 1'b0;
    logic        rd_ready_i = 1'b1;
    logic        rd_valid_o;
    logic [15:0] rd_res_o;
    logic [4:0]  rd_cell_o;
    logic        bin_ready_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int edges_left [CELLS];
    int edge_total [CELLS];
    logic [20:0] exp_q [$];

    always #(TCLK/2) clk = ~clk;

    rosg_grid dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .bin_len_i   (bin_len_i),
        .osc_i       (osc_i),
        .rd_sel_i    (rd_sel_i),
        .rd_req_i    (rd_req_i),
        .rd_ready_i  (rd_ready_i),
        .rd_valid_o  (rd_valid_o),
        .rd_res_o    (rd_res_o),
        .rd_cell_o   (rd_cell_o),
        .bin_ready_o (bin_ready_o)
    );

    function automatic logic [15:0] expect_res(input int n);
        return {4'(n % 15), 4'(n % 13), 4'(n % 11), 4'(n % 7)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic print_summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    // Monitor: pop one expected item on every accepted response.
    always @(negedge clk) begin
        if (rst_n && rd_valid_o && rd_ready_i) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected response", int'(rd_cell_o), -1);
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                check(rd_cell_o == e[20:16], "R8 cell echo", int'(rd_cell_o), int'(e[20:16]));
                check(rd_res_o == e[15:0], "R3 residues", int'(rd_res_o), int'(e[15:0]));
            end
        end
    end

    // Drive all pending edges in parallel, one rising edge per cell every four cycles.
    task automatic drive_edges();
        bit any;
        any = 1'b1;
        while (any) begin
            any = 1'b0;
            @(negedge clk);
            for (int c = 0; c < CELLS; c++) begin
                if (edges_left[c] > 0) begin
                    osc_i[c] = 1'b1;
                    edges_left[c]--;
                    any = 1'b1;
                end
            end
            repeat (2) @(negedge clk);
            osc_i = '0;
            @(negedge clk);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_ready();
        int t;
        t = 0;
        while (!bin_ready_o && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(bin_ready_o == 1'b1, "R2 bin finishes", int'(bin_ready_o), 1);
    endtask

    // Driver: push the expectation and issue one request.
    task automatic read_cell(input int c);
        exp_q.push_back({5'(c), expect_res(edge_total[c])});
        @(negedge clk);
        rd_sel_i = 5'(c);
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_all();
        for (int c = 0; c < CELLS; c++) read_cell(c);
    endtask

    initial begin
        #(TCLK * 200000);
        check(1'b0, "watchdog", 0, 1);
        print_summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(rd_valid_o == 1'b0, "R1 valid in reset", int'(rd_valid_o), 0);
        check(bin_ready_o == 1'b0, "R1 ready in reset", int'(bin_ready_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid_o == 1'b0 && bin_ready_o == 1'b0, "R1 after reset",
              int'({rd_valid_o, bin_ready_o}), 0);

        // Bin A: wrapping totals, distinct per cell (R2, R3)
        for (int c = 0; c < CELLS; c++) begin
            edge_total[c] = c * 11 + 3;
            edges_left[c] = edge_total[c];
        end
        pulse_start();
        repeat (3) @(negedge clk);
        check(bin_ready_o == 1'b0, "R2 counting window open", int'(bin_ready_o), 0);
        drive_edges();
        wait_ready();
        read_all();

        // R4: edges during readout leave residues unchanged; R8 re-read
        for (int c = 0; c < CELLS; c++) edges_left[c] = 5;
        drive_edges();
        repeat (6) @(negedge clk);
        read_all();

        // R6: out-of-range select gives no response
        @(negedge clk);
        rd_sel_i = 5'd25;
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_valid_o == 1'b0, "R6 out-of-range ignored", int'(rd_valid_o), 0);

        // R7: backpressure holds data, second request ignored
        rd_ready_i = 1'b0;
        exp_q.push_back({5'd3, expect_res(edge_total[3])});
        rd_sel_i = 5'd3;
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_valid_o == 1'b1, "R7 valid held", int'(rd_valid_o), 1);
        check(rd_res_o == expect_res(edge_total[3]), "R7 data held",
              int'(rd_res_o), int'(expect_res(edge_total[3])));
        rd_sel_i = 5'd4;
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        check(rd_cell_o == 5'd3, "R7 request ignored while held", int'(rd_cell_o), 3);
        rd_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        check(rd_valid_o == 1'b0, "R7 single response", int'(rd_valid_o), 0);

        // Bin B: small totals incl. zero, start pulsed mid-count (R5, R2 clear)
        for (int c = 0; c < CELLS; c++) begin
            edge_total[c] = (c * 7 + 1) % 40;
            edges_left[c] = edge_total[c] / 2;
        end
        pulse_start();
        repeat (3) @(negedge clk);
        drive_edges();
        pulse_start();
        for (int c = 0; c < CELLS; c++) edges_left[c] = edge_total[c] - edge_total[c] / 2;
        drive_edges();
        wait_ready();
        read_all();

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 all responses seen", exp_q.size(), 0);
        print_summary();
        $finish;
    end

endmodule